// File: doc/BRIEF.md
# Multiplexed IQ Transmit Deinterleaver

This block sits between a baseband transmit bus and a dual digital-to-analog converter. The bus is 12 bits wide and carries two's-complement samples. I and Q words take turns on it, so the bus runs at twice the converter sample rate. A frame is two back-to-back bus cycles that hold the I and Q of one sampling instant. A frame-sync flag travels with the data and shows which cycle of the pair is which. The block collects both words of a frame and presents them together as parallel I and Q words, with a one-cycle valid pulse. It also generates the converter sample strobe.

Three static configuration inputs adapt the block to the sender. One inverts the sense of the flag, one swaps the order of I and Q within a frame, and one inverts the sample strobe so that the converter can sample on either edge. The sample strobe is a registered copy of the frame-sync flag and is not a divided bus clock. If the flag stops toggling, the strobe freezes, no new frames complete and the outputs keep their last values.

Top module: `tx_iq_deinterleaver`

## Requirements
- R1: While reset is asserted, `i_word` and `q_word` are zero and `sample_valid` and `conv_strobe` are low.
- R2: With `cfg_flag_neg`=0 and `cfg_q_first`=0, a cycle with `frame_flag`=1 carries the first word of a frame. The next cycle with `frame_flag`=0 carries the second word. The first word appears on `i_word` and the second on `q_word`.
- R3: With `cfg_flag_neg`=1, the sense of the flag is inverted: `frame_flag`=0 marks the first word and `frame_flag`=1 marks the second word.
- R4: With `cfg_q_first`=1, the first word of a frame goes to `q_word` and the second word goes to `i_word`.
- R5: `sample_valid` is high for exactly the one cycle after the rising clock edge that captures the second word of a frame. It is never high in two consecutive cycles. `i_word` and `q_word` change in that same cycle.
- R6: While the flag does not change between first-word and second-word levels, `sample_valid` stays low and `i_word` and `q_word` keep their values.
- R7: After each rising edge, `conv_strobe` equals the inverse of the effective flag sampled at that edge, where the effective flag is `frame_flag` XOR `cfg_flag_neg`. This holds while `cfg_strobe_fall`=0. The strobe therefore toggles every cycle while the flag toggles, and it rises on the edge that completes a frame.
- R8: With `cfg_strobe_fall`=1, `conv_strobe` is the complement of its R7 value, so it falls on the edge that completes a frame.
- R9: When the first-word level lasts for several cycles, only the word from the last of those cycles is paired with the following second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all capture is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bus | input | 12 | Multiplexed two's-complement I/Q word |
| frame_flag | input | 1 | Frame-sync flag that marks the word slot |
| cfg_flag_neg | input | 1 | 1 inverts the sense of the frame-sync flag |
| cfg_q_first | input | 1 | 1 selects Q-then-I order within a frame |
| cfg_strobe_fall | input | 1 | 1 inverts the converter sample strobe |
| i_word | output | 12 | I sample of the last completed frame |
| q_word | output | 12 | Q sample of the last completed frame |
| sample_valid | output | 1 | One-cycle pulse when a new I/Q pair is presented |
| conv_strobe | output | 1 | Converter sample strobe, a registered copy of the flag |

## Verification
The hardest condition to reach from the ports is a broken sync pattern. In that case the flag repeats a level, the frame phase slips, and the block has to discard the earlier first words and pair only the last one. The stimulus holds the flag at the first-word level for several cycles and then at the second-word level for several cycles, using extreme data values. A random phase follows in which the flag toggles most of the time but now and then repeats a level, and the polarity, order and strobe settings change between bursts. A bench model recomputes the expected pairing in every cycle.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

  typedef enum logic {
    ORDER_I_FIRST = 1'b0,
    ORDER_Q_FIRST = 1'b1
  } word_order_e;

  typedef enum logic {
    SLOT_SECOND = 1'b0,
    SLOT_FIRST  = 1'b1
  } slot_e;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/iqd_phase_track.sv
module iqd_phase_track (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_flag,
  input  logic          cfg_flag_neg,
  input  logic          cfg_strobe_fall,
  output iqd_pkg::slot_e cur_slot,
  output logic          pair_done,
  output logic          conv_strobe
);
  import iqd_pkg::*;

  logic eff_flag;
  logic phase_q, phase_d;
  logic strobe_q, strobe_d;

  // next-state logic
  always_comb begin
    eff_flag  = frame_flag ^ cfg_flag_neg;
    cur_slot  = slot_e'(eff_flag);
    pair_done = phase_q & ~eff_flag;
    phase_d   = eff_flag;
    strobe_d  = ~eff_flag ^ cfg_strobe_fall;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      strobe_q <= strobe_d;
    end
  end

  assign conv_strobe = strobe_q;

  // A flag toggle under stable configuration toggles the strobe.
  AST_STROBE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && ($past(frame_flag) != $past(frame_flag, 2)) &&
     ($past(cfg_flag_neg) == $past(cfg_flag_neg, 2)) &&
     ($past(cfg_strobe_fall) == $past(cfg_strobe_fall, 2)))
    |-> (conv_strobe != $past(conv_strobe))); // R7

  // A repeated flag under stable configuration freezes the strobe.
  AST_STROBE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && ($past(frame_flag) == $past(frame_flag, 2)) &&
     ($past(cfg_flag_neg) == $past(cfg_flag_neg, 2)) &&
     ($past(cfg_strobe_fall) == $past(cfg_strobe_fall, 2)))
    |-> $stable(conv_strobe)); // R6

endmodule

// File: rtl/iqd_word_hold.sv
module iqd_word_hold #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign dout = hold_q;

endmodule

// File: rtl/iqd_pair_assemble.sv
module iqd_pair_assemble #(
  parameter int unsigned WORD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_done,
  input  iqd_pkg::word_order_e order,
  input  logic [WORD_W-1:0]   first_word,
  input  logic [WORD_W-1:0]   second_word,
  output logic [WORD_W-1:0]   i_word,
  output logic [WORD_W-1:0]   q_word,
  output logic                sample_valid
);
  import iqd_pkg::*;

  localparam int unsigned LANE_I = 0;
  localparam int unsigned LANE_Q = 1;

  logic [LANES-1:0][WORD_W-1:0] lane_d;
  logic [LANES-1:0][WORD_W-1:0] lane_q;
  logic                         valid_q, valid_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic take_first;
    assign take_first = (g == LANE_I) ? (order == ORDER_I_FIRST)
                                      : (order == ORDER_Q_FIRST);
    assign lane_d[g]  = pair_done ? (take_first ? first_word : second_word)
                                  : lane_q[g];
  end

  assign valid_d = pair_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      lane_q  <= lane_d;
      valid_q <= valid_d;
    end
  end

  assign i_word       = lane_q[LANE_I];
  assign q_word       = lane_q[LANE_Q];
  assign sample_valid = valid_q;

  // A frame is two bus cycles, so valid cannot repeat back to back.
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R5

  // Without a valid pulse both words keep their values.
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !sample_valid) |-> ($stable(i_word) && $stable(q_word))); // R6

endmodule

// File: rtl/tx_iq_deinterleaver.sv
module tx_iq_deinterleaver #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_bus,
  input  logic              frame_flag,
  input  logic              cfg_flag_neg,
  input  logic              cfg_q_first,
  input  logic              cfg_strobe_fall,
  output logic [WORD_W-1:0] i_word,
  output logic [WORD_W-1:0] q_word,
  output logic              sample_valid,
  output logic              conv_strobe
);
  import iqd_pkg::*;

  slot_e             cur_slot;
  logic              pair_done;
  logic              load_first;
  logic [WORD_W-1:0] first_word;
  word_order_e       order;

  assign load_first = (cur_slot == SLOT_FIRST);
  assign order      = word_order_e'(cfg_q_first);

  iqd_phase_track u_phase (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_flag      (frame_flag),
    .cfg_flag_neg    (cfg_flag_neg),
    .cfg_strobe_fall (cfg_strobe_fall),
    .cur_slot        (cur_slot),
    .pair_done       (pair_done),
    .conv_strobe     (conv_strobe)
  );

  iqd_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_first),
    .din   (tx_bus),
    .dout  (first_word)
  );

  iqd_pair_assemble #(.WORD_W(WORD_W)) u_pair (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_done    (pair_done),
    .order        (order),
    .first_word   (first_word),
    .second_word  (tx_bus),
    .i_word       (i_word),
    .q_word       (q_word),
    .sample_valid (sample_valid)
  );

  // A valid pulse needs the first-word level followed by the second-word level.
  AST_VALID_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> ($past(frame_flag ^ cfg_flag_neg, 2) &&
                      !$past(frame_flag ^ cfg_flag_neg))); // R9

  AST_ORDER_I_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !$past(cfg_q_first)) |->
      ((i_word == $past(tx_bus, 2)) && (q_word == $past(tx_bus)))); // R2

  AST_ORDER_Q_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && $past(cfg_q_first)) |->
      ((q_word == $past(tx_bus, 2)) && (i_word == $past(tx_bus)))); // R4

endmodule

// File: tb/test_tx_iq_deinterleaver.sv
module test_tx_iq_deinterleaver;

  localparam int W = 12;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] tx_bus;
  logic         frame_flag;
  logic         cfg_flag_neg;
  logic         cfg_q_first;
  logic         cfg_strobe_fall;
  logic [W-1:0] i_word;
  logic [W-1:0] q_word;
  logic         sample_valid;
  logic         conv_strobe;

  int n_checks;
  int n_errors;
  bit finished;

  // bench reference state
  logic         m_prev_eff;
  logic [W-1:0] m_hold;
  logic [W-1:0] m_i, m_q;
  logic         m_valid, m_strobe;

  tx_iq_deinterleaver #(.WORD_W(W)) i_tx_iq_deinterleaver (
    .clk             (clk),
    .rst_n           (rst_n),
    .tx_bus          (tx_bus),
    .frame_flag      (frame_flag),
    .cfg_flag_neg    (cfg_flag_neg),
    .cfg_q_first     (cfg_q_first),
    .cfg_strobe_fall (cfg_strobe_fall),
    .i_word          (i_word),
    .q_word          (q_word),
    .sample_valid    (sample_valid),
    .conv_strobe     (conv_strobe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic chk(string req, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  function automatic string word_tag();
    if (cfg_flag_neg) return "R3";
    if (cfg_q_first)  return "R4";
    return "R2";
  endfunction

  function automatic logic [W-1:0] pick(logic take_first, logic [W-1:0] a,
                                        logic [W-1:0] b);
    return take_first ? a : b;
  endfunction

  // Drive one bus cycle, advance the reference, compare after the edge.
  task automatic step(logic [W-1:0] data, logic flag, string tag_words,
                      string tag_valid);
    logic eff, done;
    tx_bus     = data;
    frame_flag = flag;
    @(posedge clk);
    eff  = flag ^ cfg_flag_neg;
    done = m_prev_eff & ~eff;
    if (done) begin
      m_i = pick(!cfg_q_first, m_hold, data);
      m_q = pick(cfg_q_first, m_hold, data);
    end
    m_valid    = done;
    m_strobe   = ~eff ^ cfg_strobe_fall;
    m_hold     = data;
    m_prev_eff = eff;
    @(negedge clk);
    chk(tag_words == "" ? word_tag() : tag_words, "i_word", int'(i_word), int'(m_i));
    chk(tag_words == "" ? word_tag() : tag_words, "q_word", int'(q_word), int'(m_q));
    chk(tag_valid, "sample_valid", int'(sample_valid), int'(m_valid));
    chk(cfg_strobe_fall ? "R8" : "R7", "conv_strobe", int'(conv_strobe), int'(m_strobe));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic flag_r;
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    tx_bus = '0;
    frame_flag = 1'b0;
    cfg_flag_neg = 1'b0;
    cfg_q_first = 1'b0;
    cfg_strobe_fall = 1'b0;
    m_prev_eff = 1'b0; m_hold = '0; m_i = '0; m_q = '0;
    m_valid = 1'b0; m_strobe = 1'b0;

    // R1: reset state, with busy inputs
    repeat (2) @(negedge clk);
    tx_bus = 12'hABC; frame_flag = 1'b1;
    @(negedge clk);
    chk("R1", "i_word", int'(i_word), 0);
    chk("R1", "q_word", int'(q_word), 0);
    chk("R1", "sample_valid", int'(sample_valid), 0);
    chk("R1", "conv_strobe", int'(conv_strobe), 0);
    rst_n = 1'b1;

    // R2: positive flag, I first, extreme values
    step(12'h7FF, 1'b1, "R2", "R5");
    step(12'h800, 1'b0, "R2", "R5");
    step(12'h123, 1'b1, "R2", "R5");
    step(12'h456, 1'b0, "R2", "R5");

    // R4: Q first
    cfg_q_first = 1'b1;
    step(12'h0A5, 1'b1, "R4", "R5");
    step(12'hF5A, 1'b0, "R4", "R5");

    // R3 and R8: inverted flag, inverted strobe
    cfg_q_first = 1'b0;
    cfg_flag_neg = 1'b1;
    cfg_strobe_fall = 1'b1;
    step(12'h321, 1'b1, "R3", "R5");
    step(12'h654, 1'b0, "R3", "R5");
    step(12'h987, 1'b1, "R3", "R5");

    // R6 and R9: first-word level stuck, then second-word level stuck
    cfg_flag_neg = 1'b0;
    cfg_strobe_fall = 1'b0;
    step(12'h111, 1'b0, "R6", "R6");
    step(12'h222, 1'b1, "R6", "R6");
    step(12'h333, 1'b1, "R6", "R6");
    step(12'h444, 1'b1, "R6", "R6");
    step(12'h800, 1'b0, "R9", "R9");
    step(12'h555, 1'b0, "R6", "R6");
    step(12'h666, 1'b0, "R6", "R6");
    step(12'h777, 1'b0, "R6", "R6");
    chk("R9", "i_word kept last first word", int'(i_word), 12'h444);

    // random bursts with occasional broken sync
    flag_r = 1'b0;
    for (int b = 0; b < 24; b++) begin
      cfg_flag_neg    = 1'($urandom_range(0, 1));
      cfg_q_first     = 1'($urandom_range(0, 1));
      cfg_strobe_fall = 1'($urandom_range(0, 1));
      for (int s = 0; s < 40; s++) begin
        if ($urandom_range(0, 7) != 0) flag_r = ~flag_r;
        step(W'($urandom), flag_r, "", "R5");
      end
    end

    summary();
  end

endmodule